// File: doc/BRIEF.md
# Stereo Tremolo Gain Stage

This block scales a stereo pair of signed 16-bit audio samples by an unsigned 16-bit gain, normally the output of a low-frequency oscillator, which produces a tremolo. Each product keeps only its upper 16 bits, so a gain of 0xFFFF passes the sample almost unchanged and a gain of 0x0000 silences it. Results are registered and appear one clock after the input strobe.

The right channel can instead take the bitwise complement of the gain. The two channels then swell in opposite directions and the sound moves back and forth between the speakers. An active-low pushbutton switches this mode on and off. The button is read only on a control-rate tick, not on every audio sample. Each press toggles the mode once. The press is re-armed only when the button is seen released on a later tick.

Top module: `tremolo_gain`

## Requirements
- R1: After reset, out_valid is 0, out_left and out_right are 0x0000 and the block is in in-phase mode, so the right channel uses the plain gain.
- R2: out_valid is 1 exactly in the cycle after a cycle with in_valid at 1, and 0 in every other cycle.
- R3: On in_valid, out_left takes bits [31:16] of the signed product of in_left (two's complement) and the zero-extended gain. For example, 0x8000 with gain 0xFFFF gives 0x8000, and any sample with gain 0x0000 gives 0x0000.
- R4: In in-phase mode, out_right takes bits [31:16] of the signed in_right times the unsigned gain.
- R5: In inverted mode, out_right uses ~gain in place of gain, so gain 0x0000 applies 0xFFFF to the right channel and gain 0xFFFF applies 0x0000. out_left still uses gain.
- R6: On a cycle with ctrl_tick at 1, btn_n at 0 and the press flag clear, the mode toggles once and the press flag is set.
- R7: While the press flag is set, ticks with btn_n at 0 do not toggle the mode. The flag is cleared only by a tick with btn_n at 1.
- R8: btn_n has no effect on cycles where ctrl_tick is 0, including pulses and bounces between ticks.
- R9: When in_valid is 0, out_left and out_right keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | 16 | Left sample, signed |
| in_right | input | 16 | Right sample, signed |
| gain | input | 16 | Modulation gain, unsigned |
| ctrl_tick | input | 1 | Control-rate strobe that qualifies the button read |
| btn_n | input | 1 | Pushbutton level, low when pressed |
| out_valid | output | 1 | Output pair strobe |
| out_left | output | 16 | Scaled left sample |
| out_right | output | 16 | Scaled right sample |

## Verification
The bench applies the gain extremes 0x0000 and 0xFFFF together with full-scale negative and positive samples. A design that treated the gain as signed, or dropped the sign extension, would turn 0x8000 at full gain into a positive value or a wrong magnitude. Inverted mode is checked at gain 0x0000, where a design that used two's-complement negation in place of the complement would wrap to zero and silence the right channel instead of passing it. The bench also holds the button low over several ticks and bounces it between ticks. A design that retoggled while the button was held, or that read the button outside ticks, would leave the mode on the wrong side, and the right-channel product shows this.

// File: rtl/tremolo_gain.sv
module tremolo_gain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  input  logic [W-1:0] gain,
  input  logic         ctrl_tick,
  input  logic         btn_n,
  output logic         out_valid,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);
  localparam int PW = 2 * W;

  logic         phase_inv;
  logic         pressed;
  logic [W-1:0] gain_r;

  assign gain_r = phase_inv ? ~gain : gain;

  logic signed [PW-1:0] prod_l, prod_r;
  assign prod_l = $signed(in_left)  * $signed({1'b0, gain});
  assign prod_r = $signed(in_right) * $signed({1'b0, gain_r});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left  <= W'(prod_l >>> W);
        out_right <= W'(prod_r >>> W);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_inv <= 1'b0;
      pressed   <= 1'b0;
    end else if (ctrl_tick) begin
      if (btn_n) begin
        pressed <= 1'b0;
      end else if (!pressed) begin
        pressed   <= 1'b1;
        phase_inv <= ~phase_inv;
      end
    end
  end
endmodule

module tremolo_gain_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] gain,
  input logic         ctrl_tick,
  input logic         btn_n,
  input logic         phase_inv,
  input logic         pressed,
  input logic         out_valid,
  input logic [W-1:0] out_left,
  input logic [W-1:0] out_right
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_left) && $stable(out_right)); // R9
  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && gain == '0 |=> out_left == '0); // R3
  AST_TOGGLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_tick && !btn_n && !pressed |=> phase_inv != $past(phase_inv) && pressed); // R6
  AST_HELD_NO_RETOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_tick && !btn_n && pressed |=> $stable(phase_inv) && pressed); // R7
  AST_NO_TICK_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_tick |=> $stable(phase_inv) && $stable(pressed)); // R8
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_tick && btn_n |=> !pressed && $stable(phase_inv)); // R7
endmodule

bind tremolo_gain tremolo_gain_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .gain(gain),
  .ctrl_tick(ctrl_tick), .btn_n(btn_n), .phase_inv(phase_inv),
  .pressed(pressed), .out_valid(out_valid), .out_left(out_left),
  .out_right(out_right)
);

// File: tb/tremolo_gain_tb.sv
module tremolo_gain_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_left = '0, in_right = '0, gain = '0;
  logic        ctrl_tick = 1'b0;
  logic        btn_n = 1'b1;
  logic        out_valid;
  logic [15:0] out_left, out_right;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  tremolo_gain dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .gain(gain), .ctrl_tick(ctrl_tick), .btn_n(btn_n),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
  );

  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {16'h8000, 16'h7FFF, 16'hFFFF},
    {16'h7FFF, 16'h8000, 16'h0000},
    {16'hFFFF, 16'h0001, 16'hFFFF},
    {16'h4000, 16'hC000, 16'h8000},
    {16'h1234, 16'hEDCC, 16'h5A5A},
    {16'h8000, 16'h8000, 16'h0001},
    {16'h0000, 16'h7FFF, 16'hA5A5},
    {16'hC350, 16'h3CB0, 16'h7FFF}
  };

  function automatic logic [15:0] mhi(logic [15:0] s, logic [15:0] g);
    logic signed [32:0] p;
    p = $signed({{17{s[15]}}, s}) * $signed({17'b0, g});
    return p[31:16];
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] l, logic [15:0] r, logic [15:0] g);
    @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r; gain = g;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic tick(logic b);
    @(negedge clk);
    btn_n = b; ctrl_tick = 1'b1;
    @(negedge clk);
    ctrl_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", {15'b0, out_valid}, 16'h0);
    chk("R1 left", out_left, 16'h0);
    chk("R1 right", out_right, 16'h0);
    rst_n = 1'b1;

    // R3 R4 R2: vector walk, in-phase
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);
      chk("R2 valid", {15'b0, out_valid}, 16'h1);
      chk("R3 left", out_left, mhi(VEC[i][47:32], VEC[i][15:0]));
      chk("R4 right", out_right, mhi(VEC[i][31:16], VEC[i][15:0]));
    end

    // R3 corners written out
    apply(16'h8000, 16'h8000, 16'hFFFF);
    chk("R3 fullneg fullgain", out_left, 16'h8000);
    chk("R4 fullneg fullgain", out_right, 16'h8000);
    apply(16'h8000, 16'h7FFF, 16'h0000);
    chk("R3 zero gain", out_left, 16'h0000);
    chk("R4 zero gain", out_right, 16'h0000);

    // R9 hold and R2 low
    in_left = 16'h1111; in_right = 16'h2222; gain = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R2 idle valid", {15'b0, out_valid}, 16'h0);
    chk("R9 hold left", out_left, 16'h0000);
    chk("R9 hold right", out_right, 16'h0000);

    // R8: bouncing between ticks does nothing
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); btn_n = k[0];
    end
    @(negedge clk); btn_n = 1'b1;
    apply(16'h8000, 16'h8000, 16'h0000);
    chk("R8 bounce no toggle", out_right, 16'h0000);

    // R6: press toggles to inverted mode, R5 complement
    tick(1'b0);
    apply(16'h8000, 16'h8000, 16'h0000);
    chk("R5 left uses gain", out_left, 16'h0000);
    chk("R5 right uses ~gain", out_right, 16'h8000);
    apply(16'h7FFF, 16'h7FFF, 16'hFFFF);
    chk("R5 left full gain", out_left, 16'h7FFE);
    chk("R5 right ~FFFF", out_right, 16'h0000);
    apply(16'h1234, 16'hC000, 16'h3000);
    chk("R5 right general", out_right, mhi(16'hC000, 16'hCFFF));

    // R7: held low over ticks, no retoggle
    tick(1'b0); tick(1'b0); tick(1'b0);
    apply(16'h0000, 16'h8000, 16'h0000);
    chk("R7 held stays inverted", out_right, 16'h8000);

    // R8: release and press without tick, still inverted
    @(negedge clk); btn_n = 1'b1;
    @(negedge clk); btn_n = 1'b0;
    @(negedge clk); btn_n = 1'b1;
    tick(1'b0);
    apply(16'h0000, 16'h8000, 16'h0000);
    chk("R8 untick release ignored", out_right, 16'h8000);

    // R7 re-arm, R6 toggle back
    tick(1'b1);
    tick(1'b0);
    apply(16'h0000, 16'h8000, 16'h0000);
    chk("R6 toggle back in-phase", out_right, 16'h0000);
    tick(1'b1);
    tick(1'b0);
    apply(16'h0000, 16'h8000, 16'h0000);
    chk("R6 second toggle inverted", out_right, 16'h8000);

    // R1: reset restores in-phase
    @(negedge clk); rst_n = 1'b0; btn_n = 1'b1;
    @(negedge clk);
    chk("R1 reset left", out_left, 16'h0000);
    chk("R1 reset right", out_right, 16'h0000);
    rst_n = 1'b1;
    apply(16'h0000, 16'h8000, 16'h0000);
    chk("R1 reset in-phase", out_right, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule